// File: doc/BRIEF.md
# Pulse-Counted Power-State Controller

This block follows the power state of a sampling converter from two asynchronous inputs: a conversion-start strobe and a serial data clock. Both inputs are brought into the system clock domain through a configurable synchronizer and reduced to single-cycle rising-edge events. The block counts conversion strobes that arrive while the serial clock is idle. A given number of such strobes moves the state from run to nap, further strobes move it to sleep, and one more brings it back to run. In the absence of serial clock activity the cycle repeats indefinitely.

Serial clock activity wakes the block from nap in either I/O standard. It wakes the block from sleep only when the CMOS wake rule is selected. Under the LVDS rule, sleep ends only on the next conversion strobe in the count. Every exit from sleep starts a settling timer. While the timer runs, the ready flag stays low. The output-enable for the data lanes is asserted only in run.

Top module: `pwr_nap_ctrl`

## Requirements
- R1: After reset, `pstate` is 2'b00 (run), `ready` is 1 and `lane_oe` is 1.
- R2: The state encoding is 2'b00 run, 2'b01 nap and 2'b10 sleep. In run, the second counted conversion rising edge moves the state to nap. The new state is visible within SYNC_STAGES+1 clock cycles of that input edge.
- R3: In nap, a serial clock rising edge returns the state to run with `ready` 1.
- R4: In nap, the third and fourth counted conversion rising edges are counted, and the fourth moves the state to sleep. Sleep is entered only from nap.
- R5: With `lvds_sel`=0 (CMOS rule), a serial clock rising edge in sleep returns the state to run.
- R6: With `lvds_sel`=1 (LVDS rule), serial clock edges in sleep have no effect and do not clear the count. In either mode, the fifth counted conversion rising edge returns the state to run and clears the count.
- R7: Outside LVDS sleep, every serial clock rising edge clears the conversion count. Alternating conversion and serial clock pulses therefore keep the state at run.
- R8: After any exit from sleep, `ready` stays 0 for exactly SETTLE_CYCLES clock cycles in run. `ready` is 0 in nap and in sleep.
- R9: `lane_oe` is 1 in run and 0 in nap and sleep.
- R10: A conversion rising edge during the settling interval is counted toward the next nap entry and does not restart the timer.
- R11: When conversion and serial clock rising edges are detected in the same cycle, the serial clock edge takes effect and the conversion edge is discarded, except in LVDS sleep.
- R12: Conversion pulses without serial clock activity cycle run, nap, sleep and back to run repeatedly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_in | input | 1 | Asynchronous conversion-start strobe |
| sck_in | input | 1 | Asynchronous serial data clock |
| lvds_sel | input | 1 | Wake rule select: 0 CMOS, 1 LVDS |
| pstate | output | 2 | Encoded power state |
| ready | output | 1 | High in run once settling is complete |
| lane_oe | output | 1 | Data-lane output enable; lanes are high-impedance when 0 |

## Verification
The hardest case to reach is the settling interval overlapping a new conversion strobe. It requires four strobes to reach sleep, an exit, and then a strobe that lands inside a window only SETTLE_CYCLES long. The bench drives the exiting strobe and counts not-ready cycles one by one. Partway through that count it raises the next strobe, then confirms the count is unchanged and that a single further strobe reaches nap. An exhaustive sweep of every six-event mix of strobes and serial clock pulses, under both wake rules, covers the remaining orderings against an arithmetic model.

// File: rtl/pwr_nap_pkg.sv
package pwr_nap_pkg;
   typedef enum logic [1:0] {
      PS_RUN   = 2'b00,
      PS_NAP   = 2'b01,
      PS_SLEEP = 2'b10
   } pstate_e;

   localparam int unsigned CNT_W = 3;
   localparam logic [CNT_W-1:0] CNT_TO_NAP   = 3'd2;
   localparam logic [CNT_W-1:0] CNT_TO_SLEEP = 3'd4;
   localparam logic [CNT_W-1:0] CNT_TO_RUN   = 3'd5;
endpackage

// File: rtl/pwr_edge_sync.sv
module pwr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES:0] chain;
   logic            prev_q;

   assign chain[0] = async_in;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g+1] <= 1'b0;
         else        chain[g+1] <= chain[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[STAGES];
   end

   assign rise = chain[STAGES] & ~prev_q;
endmodule

// File: rtl/pwr_nap_fsm.sv
module pwr_nap_fsm
   import pwr_nap_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cnv_rise,
   input  logic    sck_rise,
   input  logic    lvds_sel,
   output pstate_e state_q,
   output logic    exit_sleep
);
   pstate_e          state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
   logic             lvds_hold;

   assign cnt_inc   = cnt_q + 3'd1;
   assign lvds_hold = (state_q == PS_SLEEP) && lvds_sel;

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      exit_sleep = 1'b0;
      if (sck_rise && !lvds_hold) begin
         cnt_d = '0;
         if (state_q != PS_RUN) begin
            state_d    = PS_RUN;
            exit_sleep = (state_q == PS_SLEEP);
         end
      end else if (cnv_rise) begin
         cnt_d = cnt_inc;
         unique case (state_q)
            PS_RUN:   if (cnt_inc == CNT_TO_NAP) state_d = PS_NAP;
            PS_NAP:   if (cnt_inc == CNT_TO_SLEEP) state_d = PS_SLEEP;
            PS_SLEEP: if (cnt_inc == CNT_TO_RUN) begin
               state_d    = PS_RUN;
               cnt_d      = '0;
               exit_sleep = 1'b1;
            end
            default:  state_d = PS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
   parameter int unsigned CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned W = $clog2(CYCLES + 1);
   localparam logic [W-1:0] LOAD = W'(CYCLES);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (start)       cnt_q <= LOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/pwr_nap_ctrl.sv
module pwr_nap_ctrl
   import pwr_nap_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned SETTLE_CYCLES = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnv_in,
   input  logic       sck_in,
   input  logic       lvds_sel,
   output logic [1:0] pstate,
   output logic       ready,
   output logic       lane_oe
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end

   logic    cnv_rise, sck_rise, exit_sleep, settling;
   pstate_e state;

   pwr_edge_sync #(.STAGES(SYNC_STAGES)) u_cnv_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cnv_in), .rise(cnv_rise));

   pwr_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .async_in(sck_in), .rise(sck_rise));

   pwr_nap_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cnv_rise(cnv_rise), .sck_rise(sck_rise),
      .lvds_sel(lvds_sel), .state_q(state), .exit_sleep(exit_sleep));

   pwr_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
      .clk(clk), .rst_n(rst_n), .start(exit_sleep), .busy(settling));

   assign pstate  = state;
   assign lane_oe = (state == PS_RUN);
   assign ready   = (state == PS_RUN) && !settling;
endmodule

// File: rtl/pwr_nap_checker.sv
module pwr_nap_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pstate,
   input logic       ready,
   input logic       lane_oe,
   input logic       lvds_sel,
   input logic       sck_rise,
   input logic       cnv_rise
);
   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      pstate != 2'b11); // R2
   AST_NAP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 2'b01 && sck_rise) |=> pstate == 2'b00); // R3
   AST_SLEEP_FROM_NAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 2'b10 && $past(pstate) != 2'b10) |-> $past(pstate) == 2'b01); // R4
   AST_LVDS_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 2'b10 && lvds_sel && sck_rise && !cnv_rise) |=> pstate == 2'b10); // R6
   AST_EXIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 2'b00 && $past(pstate) == 2'b10) |-> !ready); // R8
   AST_READY_NEEDS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> lane_oe); // R9
endmodule

bind pwr_nap_ctrl pwr_nap_checker u_chk (
   .clk(clk), .rst_n(rst_n), .pstate(pstate), .ready(ready), .lane_oe(lane_oe),
   .lvds_sel(lvds_sel), .sck_rise(sck_rise), .cnv_rise(cnv_rise));

// File: tb/pwr_nap_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_nap_ctrl_bench;
   localparam int SETTLE = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnv_in = 1'b0, sck_in = 1'b0, lvds_sel = 1'b0;
   logic [1:0] pstate;
   logic       ready, lane_oe;

   int n_tests = 0, n_fail = 0, cycles = 0;
   int m_state = 0, m_cnt = 0;

   pwr_nap_ctrl #(.SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) u_pwr_nap_ctrl (
      .clk(clk), .rst_n(rst_n), .cnv_in(cnv_in), .sck_in(sck_in),
      .lvds_sel(lvds_sel), .pstate(pstate), .ready(ready), .lane_oe(lane_oe));

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         n_fail++;
         $display("FAIL watchdog: act %0d cycles exp below 190000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: act %0d exp %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic mode);
      lvds_sel = mode; cnv_in = 0; sck_in = 0; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      m_state = 0; m_cnt = 0;
   endtask

   task automatic pulse_cnv();
      cnv_in = 1; repeat (4) @(negedge clk);
      cnv_in = 0; repeat (4) @(negedge clk);
   endtask

   task automatic pulse_sck();
      sck_in = 1; repeat (4) @(negedge clk);
      sck_in = 0; repeat (4) @(negedge clk);
   endtask

   // arithmetic reference: 0 run, 1 nap, 2 sleep
   task automatic model_cnv();
      m_cnt++;
      if (m_state == 0 && m_cnt == 2) m_state = 1;
      else if (m_state == 1 && m_cnt == 4) m_state = 2;
      else if (m_state == 2 && m_cnt == 5) begin m_state = 0; m_cnt = 0; end
   endtask

   task automatic model_sck();
      if (!(m_state == 2 && lvds_sel)) begin m_cnt = 0; m_state = 0; end
   endtask

   task automatic check_model(input string req);
      repeat (SETTLE + 4) @(negedge clk);
      check(req, pstate, m_state);
      check({req, " lane_oe"}, lane_oe, m_state == 0);
      check({req, " ready"}, ready, m_state == 0);
   endtask

   initial begin
      int low;
      // R1 reset state
      do_reset(0);
      check("R1 state", pstate, 0);
      check("R1 ready", ready, 1);
      check("R1 lane_oe", lane_oe, 1);

      // R2 / R9 / R3
      pulse_cnv();
      check("R2 one pulse stays run", pstate, 0);
      pulse_cnv();
      check("R2 nap", pstate, 1);
      check("R9 lanes off in nap", lane_oe, 0);
      check("R8 not ready in nap", ready, 0);
      pulse_sck();
      check("R3 wake from nap", pstate, 0);
      check("R3 ready", ready, 1);

      // R7 serial clock between strobes
      pulse_cnv(); pulse_sck(); pulse_cnv();
      check("R7 count cleared", pstate, 0);

      // R4 / R5 CMOS sleep exit
      pulse_cnv();
      check("R7 second since clear", pstate, 1);
      pulse_cnv(); pulse_cnv();
      check("R4 sleep", pstate, 2);
      check("R9 lanes off in sleep", lane_oe, 0);
      pulse_sck();
      check("R5 CMOS wake", pstate, 0);
      check("R8 settling after CMOS wake", ready, 0);
      repeat (SETTLE) @(negedge clk);
      check("R8 ready after settle", ready, 1);

      // R6 LVDS: serial clock ignored in sleep, fifth strobe exits
      do_reset(1);
      repeat (4) pulse_cnv();
      check("R6 sleep", pstate, 2);
      pulse_sck();
      check("R6 sck ignored", pstate, 2);
      check("R6 still not ready", ready, 0);
      // R8 / R10 settle length with a strobe inside it
      cnv_in = 1;
      low = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (pstate == 0 && !ready) low++;
         if (low == 10) cnv_in = 1;
         if (low == 4) cnv_in = 0;
         if (low == 12) cnv_in = 1;
         if (low == 16) cnv_in = 0;
         if (ready) break;
      end
      cnv_in = 0;
      check("R8 settle cycles", low, SETTLE);
      check("R10 timer not restarted", ready, 1);
      repeat (4) @(negedge clk);
      pulse_cnv();
      check("R10 strobe in settle counted", pstate, 1);

      // R11 simultaneous edges
      do_reset(0);
      pulse_cnv();
      cnv_in = 1; sck_in = 1; repeat (4) @(negedge clk);
      cnv_in = 0; sck_in = 0; repeat (4) @(negedge clk);
      check("R11 stays run", pstate, 0);
      pulse_cnv();
      check("R11 strobe was discarded", pstate, 0);

      // R12 indefinite cycling
      do_reset(1);
      for (int k = 0; k < 12; k++) begin
         pulse_cnv(); model_cnv();
         check_model("R12 cycle");
      end

      // R2 R4 R5 R6 R7 exhaustive six-event sweep under both rules
      for (int mode = 0; mode < 2; mode++) begin
         for (int seq = 0; seq < 64; seq++) begin
            do_reset(mode[0]);
            for (int e = 0; e < 6; e++) begin
               if (seq[e]) begin pulse_sck(); model_sck(); end
               else begin pulse_cnv(); model_cnv(); end
               check_model("R2 R4 R5 R6 R7 sweep");
            end
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule